// File: doc/BRIEF.md
# Guarded Converter Enable Controller

This block sits behind a serial management bus decoder and guards the enable of a set of DC/DC converters together with the two output-voltage divider codes that feed them. The decoder hands it one event per completed transaction. Each event carries three things: a kind (setup, on, off, or any other command such as a read), a flag that says whether the transaction was addressed to this target, and the two 5-bit codes carried by the data bytes.

Three safeguards protect the converters. The first is on the enable itself. It rises only after two on commands in a row to this target, and it falls only after two off commands in a row. Events addressed to other targets are transparent to this count. The second is on the on command, which is refused until the codes have been loaded by a setup at least once since reset. The third is on the codes, which are locked while the enable and the external run input are both high. Only setup writes them.

The block also produces the converter shutdown flag. This flag is high unless both the enable and the run input are high. It also packs the two read-back bytes: each byte carries its code in the top five bits, the shutdown flag below the code, and zeros in the two lowest bits.

Top module: `guard_enable_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no event, both code registers read 5'b11111, the enable is low and the shutdown flag is high.
- R2: A matched setup event (kind 2'b01) that is not locked loads the low code into register 0 and the high code into register 1. The new values appear after the clock edge that samples the event.
- R3: The enable goes high at the clock edge that samples the second of two consecutive matched on events (kind 2'b10). A single on event leaves it unchanged.
- R4: The enable goes low at the clock edge that samples the second of two consecutive matched off events (kind 2'b11). A single off event leaves it unchanged.
- R5: An event with the match flag low changes neither the registers nor the enable, and it does not break a pending on or off pair.
- R6: A matched event of any other kind between the two commands of a pair clears the pending count. This includes a setup, the opposite command, and kind 2'b00. The pair must then start again.
- R7: Until the first matched setup after reset, matched on events are refused. A refused on does not count toward a pair, so the enable stays low.
- R8: On, off and other events never change the code registers.
- R9: A setup that arrives while the enable and the run input are both high is discarded, and the registers keep their values. Once the run input is low, or the enable has been cleared, setup writes again.
- R10: The shutdown flag is low exactly when the run input and the enable are both high.
- R11: Read-back byte 0 is {register 0, shutdown flag, 2'b00} and read-back byte 1 is {register 1, shutdown flag, 2'b00}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_valid_i | input | 1 | One-cycle strobe marking a completed transaction |
| evt_match_i | input | 1 | Transaction was addressed to this target |
| evt_kind_i | input | 2 | 00 other, 01 setup, 10 on, 11 off |
| code_lo_i | input | 5 | Divider code carried by the low data byte |
| code_hi_i | input | 5 | Divider code carried by the high data byte |
| run_i | input | 1 | External converter run input |
| code0_o | output | 5 | Register 0 divider code |
| code1_o | output | 5 | Register 1 divider code |
| enable_o | output | 1 | Enable state from the double-command tracker |
| shutdown_o | output | 1 | Converter shutdown flag |
| rdback0_o | output | 8 | Read-back byte for register 0 |
| rdback1_o | output | 8 | Read-back byte for register 1 |

## Verification
The bench goes after pairs that are split by other events. It splits pairs with a read, with a setup, with the opposite command, and with unmatched traffic in between. A design that counted totals instead of runs would switch the enable on the wrong command. A design that let foreign addresses reset the count would never switch at all. The bench sends on commands before any setup, and sends setups while the enable and the run input are both high: a missing guard shows up as an early enable or as overwritten codes. A long random event stream with random run-input changes is compared each cycle against a behavioural model. This catches an off-by-one in the pair count and any write of the codes by on or off.

// File: rtl/gec_pkg.sv
package gec_pkg;
  typedef enum logic [1:0] {
    EVT_OTHER = 2'b00,
    EVT_SETUP = 2'b01,
    EVT_ON    = 2'b10,
    EVT_OFF   = 2'b11
  } evt_kind_e;

  typedef enum logic [1:0] {
    PEND_NONE = 2'b00,
    PEND_ON   = 2'b01,
    PEND_OFF  = 2'b10
  } pend_e;
endpackage

// File: rtl/gec_code_regs.sv
module gec_code_regs #(
  parameter int unsigned CODE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CODE_W-1:0] lo_i,
  input  logic [CODE_W-1:0] hi_i,
  output logic [CODE_W-1:0] lo_o,
  output logic [CODE_W-1:0] hi_o
);
  localparam logic [CODE_W-1:0] RST_CODE = {CODE_W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_o <= RST_CODE;
      hi_o <= RST_CODE;
    end else if (wr_en_i) begin
      lo_o <= lo_i;
      hi_o <= hi_i;
    end
  end
endmodule

// File: rtl/gec_setup_gate.sv
module gec_setup_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic setup_hit_i,
  input  logic enable_i,
  input  logic run_i,
  output logic wr_en_o,
  output logic setup_done_o
);
  logic locked;
  assign locked  = enable_i & run_i;
  assign wr_en_o = setup_hit_i & ~locked;

  // sticky until reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      setup_done_o <= 1'b0;
    else if (wr_en_o) setup_done_o <= 1'b1;
  end
endmodule

// File: rtl/gec_pair_tracker.sv
module gec_pair_tracker
  import gec_pkg::*;
#(
  parameter int unsigned REPEAT = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      hit_i,
  input  evt_kind_e kind_i,
  input  logic      setup_done_i,
  output logic      enable_o
);
  localparam int unsigned CNT_W = $clog2(REPEAT + 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(REPEAT);

  pend_e            pend_q;
  logic [CNT_W-1:0] cnt_q;
  logic             on_ok, off_ok;
  logic [CNT_W-1:0] next_cnt;

  assign on_ok  = hit_i && kind_i == EVT_ON && setup_done_i;
  assign off_ok = hit_i && kind_i == EVT_OFF;

  always_comb begin
    next_cnt = CNT_ONE;
    if ((on_ok && pend_q == PEND_ON) || (off_ok && pend_q == PEND_OFF))
      next_cnt = cnt_q + CNT_ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= PEND_NONE;
      cnt_q    <= '0;
      enable_o <= 1'b0;
    end else if (hit_i) begin
      if ((on_ok || off_ok) && next_cnt >= CNT_DONE) begin
        enable_o <= on_ok;
        pend_q   <= PEND_NONE;
        cnt_q    <= '0;
      end else if (on_ok) begin
        pend_q <= PEND_ON;
        cnt_q  <= next_cnt;
      end else if (off_ok) begin
        pend_q <= PEND_OFF;
        cnt_q  <= next_cnt;
      end else begin
        // setup, other, or refused on breaks the run
        pend_q <= PEND_NONE;
        cnt_q  <= '0;
      end
    end
  end
endmodule

// File: rtl/guard_enable_ctrl.sv
module guard_enable_ctrl
  import gec_pkg::*;
#(
  parameter int unsigned CODE_W = 5,
  parameter int unsigned REPEAT = 2,
  parameter int unsigned PAD_W  = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      evt_valid_i,
  input  logic                      evt_match_i,
  input  logic [1:0]                evt_kind_i,
  input  logic [CODE_W-1:0]         code_lo_i,
  input  logic [CODE_W-1:0]         code_hi_i,
  input  logic                      run_i,
  output logic [CODE_W-1:0]         code0_o,
  output logic [CODE_W-1:0]         code1_o,
  output logic                      enable_o,
  output logic                      shutdown_o,
  output logic [CODE_W+PAD_W:0]     rdback0_o,
  output logic [CODE_W+PAD_W:0]     rdback1_o
);
  localparam int unsigned NUM_REG = 2;

  evt_kind_e kind;
  logic      hit, setup_hit, wr_en, setup_done;
  logic [CODE_W-1:0] codes [NUM_REG];
  logic [CODE_W+PAD_W:0] rdback [NUM_REG];

  assign kind      = evt_kind_e'(evt_kind_i);
  assign hit       = evt_valid_i & evt_match_i;
  assign setup_hit = hit && kind == EVT_SETUP;

  gec_setup_gate u_gate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .setup_hit_i  (setup_hit),
    .enable_i     (enable_o),
    .run_i        (run_i),
    .wr_en_o      (wr_en),
    .setup_done_o (setup_done)
  );

  gec_code_regs #(.CODE_W(CODE_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en),
    .lo_i    (code_lo_i),
    .hi_i    (code_hi_i),
    .lo_o    (code0_o),
    .hi_o    (code1_o)
  );

  gec_pair_tracker #(.REPEAT(REPEAT)) u_pair (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .hit_i        (hit),
    .kind_i       (kind),
    .setup_done_i (setup_done),
    .enable_o     (enable_o)
  );

  assign shutdown_o = ~(run_i & enable_o);
  assign codes[0]   = code0_o;
  assign codes[1]   = code1_o;

  for (genvar g = 0; g < NUM_REG; g++) begin : g_rdback
    assign rdback[g] = {codes[g], shutdown_o, {PAD_W{1'b0}}};
  end

  assign rdback0_o = rdback[0];
  assign rdback1_o = rdback[1];
endmodule

// File: rtl/gec_checker.sv
module gec_checker #(
  parameter int unsigned CODE_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              evt_valid_i,
  input logic              evt_match_i,
  input logic [1:0]        evt_kind_i,
  input logic              run_i,
  input logic [CODE_W-1:0] code0_o,
  input logic [CODE_W-1:0] code1_o,
  input logic              enable_o,
  input logic              setup_done
);
  a_r3_rise_needs_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(enable_o) |-> $past(evt_valid_i && evt_match_i && evt_kind_i == 2'b10));

  a_r4_fall_needs_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(enable_o) |-> $past(evt_valid_i && evt_match_i && evt_kind_i == 2'b11));

  a_r5_foreign_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && !evt_match_i) |=> ($stable(enable_o) && $stable(code0_o) && $stable(code1_o)));

  a_r7_enable_after_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_o |-> setup_done);

  a_r8_cmd_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && evt_kind_i != 2'b01) |=> ($stable(code0_o) && $stable(code1_o)));

  a_r9_locked_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && evt_match_i && evt_kind_i == 2'b01 && enable_o && run_i)
      |=> ($stable(code0_o) && $stable(code1_o)));
endmodule

bind guard_enable_ctrl gec_checker #(.CODE_W(CODE_W)) u_gec_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .evt_valid_i (evt_valid_i),
  .evt_match_i (evt_match_i),
  .evt_kind_i  (evt_kind_i),
  .run_i       (run_i),
  .code0_o     (code0_o),
  .code1_o     (code1_o),
  .enable_o    (enable_o),
  .setup_done  (setup_done)
);

// File: tb/guard_enable_ctrl_tb_top.sv
module guard_enable_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0, match = 1'b0, run = 1'b0;
  logic [1:0] kind = 2'b00;
  logic [4:0] lo = '0, hi = '0;
  logic [4:0] c0, c1;
  logic       en, sd;
  logic [7:0] rb0, rb1;

  int n_chk = 0, n_bad = 0;
  string phase = "R1";

  // behavioural model
  int m_r0 = 31, m_r1 = 31, m_en = 0, m_setup = 0, m_pend = 0, m_cnt = 0;

  always #2 clk = ~clk;

  guard_enable_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .evt_valid_i(valid), .evt_match_i(match),
    .evt_kind_i(kind), .code_lo_i(lo), .code_hi_i(hi), .run_i(run),
    .code0_o(c0), .code1_o(c1), .enable_o(en), .shutdown_o(sd),
    .rdback0_o(rb0), .rdback1_o(rb1)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_r0 = 31; m_r1 = 31; m_en = 0; m_setup = 0; m_pend = 0; m_cnt = 0;
    end else if (valid && match) begin
      if (kind == 2'b01) begin
        if (!(m_en == 1 && run)) begin
          m_r0 = lo; m_r1 = hi; m_setup = 1;
        end
        m_pend = 0; m_cnt = 0;
      end else if ((kind == 2'b10 && m_setup == 1) || kind == 2'b11) begin
        int want;
        want = (kind == 2'b10) ? 1 : 2;
        m_cnt = (m_pend == want) ? m_cnt + 1 : 1;
        m_pend = want;
        if (m_cnt >= 2) begin
          m_en = (want == 1) ? 1 : 0; m_pend = 0; m_cnt = 0;
        end
      end else begin
        m_pend = 0; m_cnt = 0;
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      int m_sd;
      m_sd = (run && m_en == 1) ? 0 : 1;
      chk(phase, "code0", c0, m_r0);
      chk(phase, "code1", c1, m_r1);
      chk(phase, "enable", en, m_en);
      chk(phase, "shutdown", sd, m_sd);
      chk(phase, "rdback0", rb0, m_r0 * 8 + m_sd * 4);
      chk(phase, "rdback1", rb1, m_r1 * 8 + m_sd * 4);
    end
  end

  task automatic evt(input logic [1:0] k, input logic m, input logic [4:0] l, input logic [4:0] h);
    @(negedge clk);
    valid = 1'b1; kind = k; match = m; lo = l; hi = h;
    @(negedge clk);
    valid = 1'b0;
    #1;
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    phase = "R1";
    #5;
    chk("R1", "reset code0", c0, 31);
    chk("R1", "reset shutdown", sd, 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "post-reset code1", c1, 31);
    chk("R1", "post-reset enable", en, 0);

    phase = "R7";
    evt(2'b10, 1, 0, 0); evt(2'b10, 1, 0, 0);
    chk("R7", "on before setup", en, 0);

    phase = "R2";
    evt(2'b01, 1, 5'h0A, 5'h15);
    chk("R2", "code0 loaded", c0, 5'h0A);
    chk("R2", "code1 loaded", c1, 5'h15);

    phase = "R11";
    chk("R11", "rdback0", rb0, 8'h54);
    chk("R11", "rdback1", rb1, 8'hAC);

    phase = "R3";
    evt(2'b10, 1, 1, 1);
    chk("R3", "single on", en, 0);
    evt(2'b10, 1, 1, 1);
    chk("R3", "double on", en, 1);

    phase = "R10";
    @(negedge clk); run = 1'b0; #1;
    chk("R10", "run low", sd, 1);
    @(negedge clk); run = 1'b1; #1;
    chk("R10", "run high", sd, 0);

    phase = "R9";
    evt(2'b01, 1, 5'h03, 5'h04);
    chk("R9", "locked code0", c0, 5'h0A);
    @(negedge clk); run = 1'b0;
    evt(2'b01, 1, 5'h03, 5'h04);
    chk("R9", "unlocked code0", c0, 5'h03);
    @(negedge clk); run = 1'b1;

    phase = "R8";
    evt(2'b11, 1, 5'h1F, 5'h1F);
    chk("R8", "code0 after off", c0, 5'h03);
    chk("R8", "single off", en, 1);

    phase = "R6";
    evt(2'b00, 1, 0, 0); evt(2'b11, 1, 0, 0);
    chk("R6", "read splits off pair", en, 1);
    evt(2'b11, 1, 0, 0);
    chk("R4", "double off", en, 0);
    evt(2'b10, 1, 0, 0); evt(2'b01, 1, 5'h07, 5'h08); evt(2'b10, 1, 0, 0);
    chk("R6", "setup splits on pair", en, 0);
    evt(2'b11, 1, 0, 0); evt(2'b10, 1, 0, 0);
    chk("R6", "off splits on pair", en, 0);

    phase = "R5";
    evt(2'b11, 0, 0, 0); evt(2'b10, 1, 0, 0);
    chk("R5", "foreign off keeps pair", en, 1);
    evt(2'b11, 1, 0, 0); evt(2'b01, 0, 5'h11, 5'h12); evt(2'b11, 1, 0, 0);
    chk("R5", "foreign setup keeps pair", en, 0);
    chk("R5", "foreign setup no write", c0, 5'h07);

    phase = "R4";
    for (int i = 0; i < 400; i++) begin
      if (i % 37 == 0) begin @(negedge clk); run = 1'($urandom_range(0, 1)); end
      evt(2'($urandom_range(0, 3)), 1'($urandom_range(0, 3) != 0),
          5'($urandom_range(0, 31)), 5'($urandom_range(0, 31)));
    end

    phase = "R1";
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R1", "re-reset code0", c0, 31);
    chk("R1", "re-reset enable", en, 0);
    @(negedge clk); rst_n = 1'b1;
    phase = "R7";
    evt(2'b10, 1, 0, 0); evt(2'b10, 1, 0, 0);
    chk("R7", "setup flag cleared by reset", en, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule